// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a synchronous host and one x16 extended-data-out DRAM. It turns host word requests into the active-low strobe sequences the memory needs. The strobes are a row strobe, a CAS strobe for each byte lane, a write enable and an output enable, plus a shared row/column address bus. A request first opens a row. Further requests to the same row are served as page-mode column cycles. A request to another row closes the open row, waits out the row precharge and opens the new row. Reads are sampled late in the CAS precharge, while the DRAM still holds its data out. Writes are always early writes. Refresh uses CAS-before-RAS cycles issued at a fixed interval.

Every timing figure is given in nanoseconds and turned into a clock count, rounded up, when the block is elaborated. A single parameter picks the refresh organisation. With 4096 rows, the 22-bit word address splits into 12 row bits and 10 column bits. With 8192 rows, it splits into 13 row bits and 9 column bits.

The request port is valid/ready. The host raises `req_valid` and holds the address, write flag, write data and byte enable stable until `req_ready` is high at a rising edge. The transfer takes place on that edge. `req_ready` may depend on the request address, because a page hit is judged against it. Read data comes back as a single-cycle `rd_valid` pulse. This return path has no back-pressure, so the host must always be able to take it. The byte enable must not be 00.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n`, `cas_lo_n`, `cas_hi_n`, `we_n` and `oe_n` are all 1, and `rd_valid` and `dq_oe` are 0.
- R2: When the row strobe falls for an access, `dram_addr` carries the upper address bits `req_addr[21:COL_W]`. When a CAS strobe falls, `dram_addr` carries `req_addr[COL_W-1:0]` zero-extended. COL_W is 10 for the 4096-row organisation and 9 for the 8192-row organisation.
- R3: A write lowers `we_n` at least one cycle before its CAS strobe falls. It keeps `we_n` low while that strobe falls, with `oe_n` high and `dq_oe` high.
- R4: `req_be[0]` selects `cas_lo_n` (DQ7..0) and `req_be[1]` selects `cas_hi_n` (DQ15..8). When both lanes are enabled, they fall in the same cycle.
- R5: A read keeps `we_n` high and drives `oe_n` low. It returns exactly one `rd_valid` pulse, with data equal to the last data written to that word (0 if never written). The pulse comes while the row strobe is low, both CAS strobes are high and `oe_n` is low.
- R6: A request accepted while a row is open is served with no rise of the row strobe before its CAS strobe falls.
- R7: Before the row strobe falls, it has been high for at least C_RP cycles (4 by default).
- R8: A refresh lowers both CAS strobes at least one cycle before the row strobe falls, with `we_n` high.
- R9: While a refresh is due, `req_ready` stays low. An open row is closed and the refresh starts before any further request is taken, so refreshes are never more than the refresh interval plus one access apart.
- R10: Default timing is met. The row strobe stays low for at least 7 cycles. A CAS strobe falls at least 4 cycles after the row strobe fell. Between page cycles, the CAS strobes stay high for at least 2 cycles.
- R11: Each request is accepted exactly once, only on an edge where `req_valid` and `req_ready` are both high. It produces exactly one column access, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge when valid is also high |
| req_addr | input | ADDR_W (22) | Word address, row bits above column bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enable, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle read return strobe |
| rd_data | output | 16 | Read data, valid with rd_valid |
| dram_addr | output | A_W (12) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Low-byte column strobe, active low |
| cas_hi_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_o | output | 16 | Data driven toward the DRAM |
| dq_oe | output | 1 | Enables the data pad drivers |
| dq_i | input | 16 | Data returned from the DRAM |

## Verification
The block is first driven with runs of full-word and single-byte writes to one row, followed by reads of the same row. This separates correct page-hit handling and lane selection from a controller that reopens the row or drives the wrong lane. Traffic that alternates between two rows and includes the last row and last column then forces a close and reopen on every request, which exposes a wrong row/column split or a short precharge. A long idle gap with a row left open, and a long pseudo-random mix of reads and writes over a few rows, show whether a refresh pre-empts an open page and traffic in time and leaves stored data intact.

// File: rtl/edo_pkg.sv
package edo_pkg;

  localparam int DW  = 16;
  localparam int BEW = DW / 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_CP,
    ST_OPEN,
    ST_PRE,
    ST_REFC,
    ST_REFR
  } seq_st_e;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ADDR_W = 22,
  parameter int COL_W  = 10,
  parameter int A_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [A_W-1:0]    row_bus,
  output logic [A_W-1:0]    col_bus
);

  localparam int ROW_W = ADDR_W - COL_W;

  generate
    if (A_W > ROW_W) begin : g_row_pad
      assign row_bus = {{(A_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
    end else begin : g_row_full
      assign row_bus = addr[ADDR_W-1:COL_W];
    end
    if (A_W > COL_W) begin : g_col_pad
      assign col_bus = {{(A_W-COL_W){1'b0}}, addr[COL_W-1:0]};
    end else begin : g_col_full
      assign col_bus = addr[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int C_REF = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);

  localparam int TW = $clog2(C_REF + 1);

  logic [TW-1:0] cnt;
  logic          fire;

  assign fire = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= TW'(C_REF - 1);
      pend <= 1'b0;
    end else begin
      cnt <= fire ? TW'(C_REF - 1) : cnt - 1'b1;
      if (fire)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int A_W      = 12,
  parameter int C_RCD    = 3,
  parameter int C_CAS    = 1,
  parameter int C_CP     = 2,
  parameter int C_RP     = 4,
  parameter int C_RASMIN = 7,
  parameter int CNT_W    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [A_W-1:0] req_row,
  input  logic [A_W-1:0] req_col,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BEW-1:0] req_be,
  input  logic           ref_pend,
  output logic           ref_ack,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic [A_W-1:0] dram_addr,
  output logic           ras_n,
  output logic           cas_lo_n,
  output logic           cas_hi_n,
  output logic           we_n,
  output logic           oe_n,
  output logic [DW-1:0]  dq_o,
  output logic           dq_oe,
  input  logic [DW-1:0]  dq_i
);

  seq_st_e          st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ras_cnt;
  logic [A_W-1:0]   open_row, lat_col, n_row, n_col;
  logic             lat_wr, n_wr;
  logic [BEW-1:0]   lat_be, n_be;
  logic [DW-1:0]    lat_wd, n_wd;
  logic             hit, accept, ras_ok, cnt_done;
  logic             ras_d, cl_d, ch_d, we_d, oe_d, dqoe_d, wr_ph, cbr;
  logic [A_W-1:0]   addr_d;

  assign hit      = (req_row == open_row);
  assign ras_ok   = (ras_cnt >= CNT_W'(C_RASMIN));
  assign cnt_done = (cnt == '0);

  always_comb begin
    req_ready = 1'b0;
    if (!ref_pend) begin
      if (st == ST_IDLE)
        req_ready = 1'b1;
      else if (st == ST_OPEN && hit)
        req_ready = 1'b1;
    end
  end

  assign accept  = req_valid && req_ready;
  assign ref_ack = (st == ST_IDLE) && ref_pend;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (ref_pend)    nxt = ST_REFC;
        else if (accept) nxt = ST_ROW;
      end
      ST_ROW:  nxt = ST_RCD;
      ST_RCD:  if (cnt_done) nxt = ST_COL;
      ST_COL:  nxt = ST_CAS;
      ST_CAS:  if (cnt_done) nxt = ST_CP;
      ST_CP:   if (cnt_done) nxt = ST_OPEN;
      ST_OPEN: begin
        if (accept)
          nxt = ST_COL;
        else if ((ref_pend || req_valid) && ras_ok)
          nxt = ST_PRE;
      end
      ST_PRE:  if (cnt_done) nxt = ST_IDLE;
      ST_REFC: nxt = ST_REFR;
      ST_REFR: if (cnt_done) nxt = ST_PRE;
      default: nxt = ST_IDLE;
    endcase
  end

  function automatic logic [CNT_W-1:0] dur(input seq_st_e s);
    case (s)
      ST_RCD:  return CNT_W'(C_RCD - 1);
      ST_CAS:  return CNT_W'(C_CAS - 1);
      ST_CP:   return CNT_W'(C_CP - 1);
      ST_PRE:  return CNT_W'(C_RP - 1);
      ST_REFR: return CNT_W'(C_RASMIN - 1);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    n_row = (accept && st == ST_IDLE) ? req_row : open_row;
    n_col = accept ? req_col   : lat_col;
    n_wr  = accept ? req_write : lat_wr;
    n_be  = accept ? req_be    : lat_be;
    n_wd  = accept ? req_wdata : lat_wd;
  end

  always_comb begin
    cbr    = (nxt == ST_REFC) || (nxt == ST_REFR);
    ras_d  = !(nxt inside {ST_RCD, ST_COL, ST_CAS, ST_CP, ST_OPEN, ST_REFR});
    cl_d   = !(((nxt == ST_CAS) && n_be[0]) || cbr);
    ch_d   = !(((nxt == ST_CAS) && n_be[1]) || cbr);
    wr_ph  = n_wr && (nxt inside {ST_COL, ST_CAS, ST_CP});
    we_d   = !wr_ph;
    dqoe_d = wr_ph;
    oe_d   = !(!n_wr && (nxt inside {ST_COL, ST_CAS, ST_CP, ST_OPEN}));
    addr_d = (nxt inside {ST_ROW, ST_RCD}) ? n_row : n_col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      ras_cnt   <= '0;
      open_row  <= '0;
      lat_col   <= '0;
      lat_wr    <= 1'b0;
      lat_be    <= '0;
      lat_wd    <= '0;
      ras_n     <= 1'b1;
      cas_lo_n  <= 1'b1;
      cas_hi_n  <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_o      <= '0;
      dram_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)
        cnt <= dur(nxt);
      else if (!cnt_done)
        cnt <= cnt - 1'b1;
      if (ras_n)
        ras_cnt <= '0;
      else if (!ras_ok)
        ras_cnt <= ras_cnt + 1'b1;
      open_row  <= n_row;
      lat_col   <= n_col;
      lat_wr    <= n_wr;
      lat_be    <= n_be;
      lat_wd    <= n_wd;
      ras_n     <= ras_d;
      cas_lo_n  <= cl_d;
      cas_hi_n  <= ch_d;
      we_n      <= we_d;
      oe_n      <= oe_d;
      dq_oe     <= dqoe_d;
      dq_o      <= n_wd;
      dram_addr <= addr_d;
      rd_valid  <= (st == ST_CP) && cnt_done && !lat_wr;
      if ((st == ST_CP) && cnt_done && !lat_wr)
        rd_data <= dq_i;
    end
  end

  // Checker state: cycles the row strobe has been high, saturating.
  logic [CNT_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_cnt <= CNT_W'(C_RP);
    else if (!ras_n)
      hi_cnt <= '0;
    else if (hi_cnt < CNT_W'(C_RP))
      hi_cnt <= hi_cnt + 1'b1;
  end

  assert_ras_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= CNT_W'(C_RP)));

  assert_cbr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_lo_n) |-> ($past(!cas_lo_n && !cas_hi_n) && !cas_hi_n && we_n));

  assert_early_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(cas_lo_n) || $fell(cas_hi_n)) && !we_n) |-> ($past(!we_n) && oe_n && dq_oe));

  assert_lanes_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_lo_n && !cas_hi_n && ($fell(cas_lo_n) || $fell(cas_hi_n)))
      |-> ($fell(cas_lo_n) && $fell(cas_hi_n)));

  assert_read_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!ras_n && cas_lo_n && cas_hi_n && !oe_n && we_n));

  assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter bit REFRESH_8K = 1'b0,
  parameter int CLK_NS     = 8,
  parameter int T_RC_NS    = 84,
  parameter int T_RP_NS    = 30,
  parameter int T_PC_NS    = 20,
  parameter int T_CAS_NS   = 8,
  parameter int T_RAC_NS   = 50,
  parameter int T_AA_NS    = 25,
  parameter int T_CAC_NS   = 13,
  parameter int T_REFI_NS  = 15600,
  parameter int ROW_W      = REFRESH_8K ? 13 : 12,
  parameter int A_W        = ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [A_W-1:0]    dram_addr,
  output logic              ras_n,
  output logic              cas_lo_n,
  output logic              cas_hi_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [15:0]       dq_o,
  output logic              dq_oe,
  input  logic [15:0]       dq_i
);

  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int C_RC     = cyc_ceil(T_RC_NS, CLK_NS);
  localparam int C_RP     = max2(1, cyc_ceil(T_RP_NS, CLK_NS));
  localparam int C_PC     = cyc_ceil(T_PC_NS, CLK_NS);
  localparam int C_CAS    = max2(1, cyc_ceil(T_CAS_NS, CLK_NS));
  localparam int C_RAC    = cyc_ceil(T_RAC_NS, CLK_NS);
  localparam int C_AA     = cyc_ceil(T_AA_NS, CLK_NS);
  localparam int C_CAC    = cyc_ceil(T_CAC_NS, CLK_NS);
  localparam int C_CP     = max2(1, max2(C_AA - 1 - C_CAS,
                                         max2(C_CAC - C_CAS, C_PC - 1 - C_CAS)));
  localparam int C_RCD    = max2(1, C_RAC - 1 - C_CAS - C_CP);
  localparam int C_RASMIN = max2(C_RCD + 1 + C_CAS + C_CP, C_RC - C_RP);
  localparam int C_REF    = max2(2, cyc_ceil(T_REFI_NS, CLK_NS));
  localparam int C_MAX    = max2(max2(C_RCD, C_RASMIN), max2(C_RP, max2(C_CP, C_CAS)));
  localparam int CNT_W    = $clog2(C_MAX + 2);

  logic [A_W-1:0] req_row, req_col;
  logic           ref_pend, ref_ack;

  edo_addr_split #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .A_W    (A_W)
  ) u_split (
    .addr    (req_addr),
    .row_bus (req_row),
    .col_bus (req_col)
  );

  edo_refresh_timer #(
    .C_REF (C_REF)
  ) u_reftmr (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  edo_seq #(
    .A_W      (A_W),
    .C_RCD    (C_RCD),
    .C_CAS    (C_CAS),
    .C_CP     (C_CP),
    .C_RP     (C_RP),
    .C_RASMIN (C_RASMIN),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .cas_lo_n  (cas_lo_n),
    .cas_hi_n  (cas_hi_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .dq_i      (dq_i)
  );

  assert_refresh_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

endmodule

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;

  localparam int COLB   = 10;
  localparam int REF_CY = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [11:0] dram_addr;
  logic        ras_n, cas_lo_n, cas_hi_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_o;
  logic [15:0] dq_i = 16'hBAD0;

  always #4 clk = ~clk;

  edo_page_ctrl #(.T_REFI_NS(REF_CY * 8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected accesses and shadow storage
  int          qa[$];
  bit          qw[$];
  logic [1:0]  qb[$];
  bit          qh[$];
  logic [15:0] qr[$];
  logic [15:0] sh[int];
  logic [15:0] dm[int];

  // Behavioural DRAM and timing observer
  int   cyc = 0, since_ref = 0, ref_cnt = 0;
  int   ras_lo_len = 0, ras_hi_len = 100, cas_hi_len = 100;
  int   ras_fall_cyc = 0, cur_row = 0, rd_loc = 0;
  bit   first_in_row = 1, rd_ok = 0, p_rdv = 0;
  logic p_ras = 1, p_cl = 1, p_ch = 1, p_we = 1;

  always @(negedge clk) begin : mdl
    int a, key;
    bit w;
    logic [1:0] b;
    logic [15:0] old, e;
    if (rst_n) begin
      cyc++;
      since_ref++;
      if (p_ras && !ras_n) begin
        chk(ras_hi_len >= 4, "R7", "row precharge cycles", ras_hi_len, 4);
        if (!cas_lo_n) begin
          chk(!p_cl && !p_ch && !cas_hi_n && we_n, "R8", "cbr order",
              {p_cl, p_ch, cas_hi_n, we_n}, 4'b0001);
          chk(since_ref <= REF_CY + 20, "R9", "refresh gap", since_ref, REF_CY + 20);
          since_ref = 0;
          ref_cnt++;
        end else begin
          cur_row = int'(dram_addr);
          ras_fall_cyc = cyc;
          first_in_row = 1;
        end
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo_len >= 7, "R10", "row strobe low cycles", ras_lo_len, 7);
        if (qh.size() > 0 && qh[0]) chk(0, "R6", "row closed under page hit", 1, 0);
        rd_ok = 0;
      end
      if (!ras_n && !p_ras && ((p_cl && !cas_lo_n) || (p_ch && !cas_hi_n))) begin
        chk(cyc - ras_fall_cyc >= 4, "R10", "row to column cycles", cyc - ras_fall_cyc, 4);
        if (!first_in_row)
          chk(cas_hi_len >= 2, "R10", "cas precharge cycles", cas_hi_len, 2);
        first_in_row = 0;
        if (qa.size() == 0) begin
          chk(0, "R11", "access without request", 0, 1);
        end else begin
          a = qa.pop_front(); w = qw.pop_front(); b = qb.pop_front(); void'(qh.pop_front());
          chk(cur_row == (a >> COLB), "R2", "row address", cur_row, a >> COLB);
          chk(int'(dram_addr) == (a & 1023), "R2", "column address", dram_addr, a & 1023);
          chk({!cas_hi_n, !cas_lo_n} == b, "R4", "lane strobes", {!cas_hi_n, !cas_lo_n}, b);
          key = cur_row * 1024 + int'(dram_addr);
          if (w) begin
            chk(!we_n && !p_we && oe_n && dq_oe, "R3", "early write pins",
                {we_n, p_we, oe_n, dq_oe}, 4'b0011);
            old = dm.exists(key) ? dm[key] : 16'h0;
            if (!cas_lo_n) old[7:0]  = dq_o[7:0];
            if (!cas_hi_n) old[15:8] = dq_o[15:8];
            dm[key] = old;
            rd_ok = 0;
          end else begin
            chk(we_n, "R5", "we high on read", we_n, 1);
            rd_ok = 1;
            rd_loc = key;
          end
        end
      end
      if (rd_valid) begin
        chk(!p_rdv, "R5", "single read pulse", p_rdv, 0);
        if (qr.size() == 0) chk(0, "R5", "read without request", 0, 1);
        else begin
          e = qr.pop_front();
          chk(rd_data == e, "R5", "read data", rd_data, e);
        end
      end
      ras_lo_len = ras_n ? 0 : ras_lo_len + 1;
      ras_hi_len = ras_n ? ras_hi_len + 1 : 0;
      cas_hi_len = (cas_lo_n && cas_hi_n) ? cas_hi_len + 1 : 0;
      p_rdv = rd_valid;
    end
    if (!ras_n && !oe_n && we_n && rd_ok)
      dq_i = dm.exists(rd_loc) ? dm[rd_loc] : 16'h0;
    else
      dq_i = 16'hBAD0;
    p_ras = ras_n; p_cl = cas_lo_n; p_ch = cas_hi_n; p_we = we_n;
  end

  task automatic do_req(input int a, input bit w, input logic [15:0] d, input logic [1:0] b);
    logic [15:0] old;
    @(negedge clk);
    #1;
    req_valid = 1'b1; req_addr = 22'(a); req_write = w; req_wdata = d; req_be = b;
    forever begin
      #1;
      if (req_ready) begin
        qa.push_back(a); qw.push_back(w); qb.push_back(b); qh.push_back(!ras_n);
        if (w) begin
          old = sh.exists(a) ? sh[a] : 16'h0;
          if (b[0]) old[7:0]  = d[7:0];
          if (b[1]) old[15:8] = d[15:8];
          sh[a] = old;
        end else begin
          qr.push_back(sh.exists(a) ? sh[a] : 16'h0);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  function automatic int mk(input int row, input int col);
    return (row << COLB) | col;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    bit [31:0] s;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_lo_n && cas_hi_n && we_n && oe_n, "R1", "strobes in reset",
        {ras_n, cas_lo_n, cas_hi_n, we_n, oe_n}, 5'h1f);
    chk(!rd_valid && !dq_oe, "R1", "outputs in reset", {rd_valid, dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_lo_n && cas_hi_n && we_n && oe_n && !dq_oe, "R1", "after reset",
        {ras_n, cas_lo_n, cas_hi_n, we_n, oe_n, dq_oe}, 6'h3e);

    // Pattern 1: full-word writes in one row, read back as page hits (R6)
    for (int c = 0; c < 8; c++) do_req(mk(5, c), 1, 16'h1100 + 16'(c * 17), 2'b11);
    for (int c = 0; c < 8; c++) do_req(mk(5, c), 0, 16'h0, 2'b11);
    // Pattern 2: single-lane writes (R4)
    do_req(mk(5, 3), 1, 16'hAAEE, 2'b01);
    do_req(mk(5, 4), 1, 16'hCC77, 2'b10);
    do_req(mk(5, 3), 0, 16'h0, 2'b01);
    do_req(mk(5, 4), 0, 16'h0, 2'b11);
    // Pattern 3: row misses, extreme row and column (R2, R7)
    for (int i = 0; i < 6; i++) begin
      do_req(mk(9, 1023), 1, 16'h5A00 + 16'(i), 2'b11);
      do_req(mk(4095, 0), 1, 16'hA500 + 16'(i), 2'b11);
      do_req(mk(9, 1023), 0, 16'h0, 2'b11);
      do_req(mk(5, 2), 0, 16'h0, 2'b11);
    end
    // Pattern 4: leave a row open while a refresh falls due (R9)
    do_req(mk(200, 7), 1, 16'hBEEF, 2'b11);
    repeat (250) @(negedge clk);
    do_req(mk(200, 7), 0, 16'h0, 2'b11);
    // Pattern 5: pseudo-random mix over few rows
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int row, col;
      s = s * 32'd1103515245 + 32'd12345;
      case (s[25:24])
        2'd0: row = 5;
        2'd1: row = 9;
        2'd2: row = 200;
        default: row = 4095;
      endcase
      col = (s[20:19] == 2'b11) ? 1023 : int'(s[18:16]);
      do_req(mk(row, col), s[30], 16'(s[15:0] ^ 16'(i)), (s[28:27] == 2'b00) ? 2'b11 : s[28:27]);
    end

    repeat (60) @(negedge clk);
    chk(qa.size() == 0, "R11", "requests without access", qa.size(), 0);
    chk(qr.size() == 0, "R5", "reads without return", qr.size(), 0);
    chk(ref_cnt >= cyc / (REF_CY + 20), "R8", "refresh count", ref_cnt, cyc / (REF_CY + 20));
    done = 1;
    summary();
    $finish;
  end

endmodule